// File: doc/BRIEF.md
# Nibble-Striped Lane Serializer

The block takes 32-bit words from an upstream source over a valid/ready handshake and spreads every word across eight serial lanes. Lane n always carries the same nibble of each word, bits [4n+3:4n], sent most significant bit first, one bit per clock. All eight lanes shift in lockstep, so one word takes four bit-times. Two neighbouring lanes together carry one byte of the word.

Words are grouped into logical units (LUs). The LU length is given in bytes on a configuration input (16 to 20) and is turned into a whole number of 4-byte words. The block keeps its own word count and raises a framing strobe on every lane during the first bit-time of each LU's first word. A start-of-LU marker that comes with an input word forces a new LU to begin at that word. The configured length is read only when an LU begins, so a length change never shortens or stretches an LU that is already being sent.

Top module: `nibble_lane_serializer`

## Requirements
- R1: Lane n (n = 0..7) carries bits [4n+3:4n] of each accepted word. The nibble's most significant bit appears on the lane in the cycle after the accepting clock edge, and the remaining bits follow in descending order, one per cycle.
- R2: All eight lanes shift together, and `lane_busy` is high for exactly the four bit-times of each word.
- R3: `in_ready` is high when no word is being shifted and during the last bit-time of a word. It is low during the first three bit-times. A word accepted on the last bit-time starts shifting in the next cycle, leaving no gap.
- R4: The LU length in words is the configured byte count divided by 4 and rounded up: 16 bytes gives 4 words, and 17 to 20 bytes give 5 words.
- R5: A configured byte count below 16 is treated as 16, and one above 20 is treated as 20.
- R6: The length setting is captured only when the first word of an LU is accepted. A change made while an LU is in progress takes effect at the next LU.
- R7: Every bit of `lane_frame` is high during the first bit-time of the first word of each LU. All of its bits are low at every other time.
- R8: A word accepted with `in_sol` high always begins a new LU, even when the current LU has not yet reached its length.
- R9: After reset, and whenever no word is being shifted, `in_ready` is 1 while `lane_busy`, `lane_data` and `lane_frame` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit-time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lu_bytes | input | 5 | LU length in bytes (16 to 20, clamped outside that range) |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word in this cycle |
| in_data | input | 32 | Input word |
| in_sol | input | 1 | Input word is the first word of a new LU |
| lane_data | output | 8 | Serial bit of each lane; bit n is lane n |
| lane_frame | output | 8 | LU framing strobe, one bit per lane |
| lane_busy | output | 1 | A word is being shifted out |

## Verification
The bench sends words whose lanes each hold a distinct nibble, then rebuilds every word from the lane bits. A lane swap, a bit-order reversal or a dropped bit-time therefore shows up as a wrong word. It streams LUs back to back at 16, 17, 18 and 20 bytes, and at out-of-range settings, so that a wrong word count or missing clamping moves the framing strobe onto the wrong word. The length setting is also changed in the middle of an LU, which catches a design that reads it on every word and cuts the LU short. A start marker is raised in the middle of an LU, and idle gaps are left between words: a design that ignored the marker would miss a frame, and one that leaked stale bits would drive non-zero lanes while idle.

// File: rtl/nls_pkg.sv
// Package: shared helpers for the nibble-striped lane serializer.
// Assumes byte counts fit in an int unsigned.
package nls_pkg;

    // Phase of the per-word bit timer.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    // Clamp a byte count to [min_b, max_b] and round it up to whole words.
    function automatic int unsigned lu_word_count(
        input int unsigned bytes,
        input int unsigned min_b,
        input int unsigned max_b,
        input int unsigned word_bytes
    );
        int unsigned b;
        b = (bytes < min_b) ? min_b : ((bytes > max_b) ? max_b : bytes);
        return (b + word_bytes - 1) / word_bytes;
    endfunction

endpackage

// File: rtl/nls_bit_timer.sv
// Module: bit-time counter for one word in flight.
// Holds the shift phase and bit index, raises ready when idle or on the
// last bit-time. Assumes BITS >= 2 and that load is only pulsed while
// ready is high.
module nls_bit_timer
    import nls_pkg::*;
#(
    parameter int BITS  = 4,
    parameter int CNT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic             busy,
    output logic [CNT_W-1:0] bit_idx,
    output logic             ready
);

    phase_e     phase;
    logic       last_bit;

    // Last bit-time of the current word.
    assign last_bit = (phase == PH_SHIFT) && (bit_idx == CNT_W'(BITS - 1));
    // A new word fits when nothing shifts or the current one ends now.
    assign ready    = (phase == PH_IDLE) || last_bit;
    assign busy     = (phase == PH_SHIFT);

    // Advance the bit index, restart it on a load, go idle after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
        end else if (load) begin
            phase   <= PH_SHIFT;
            bit_idx <= '0;
        end else if (phase == PH_SHIFT) begin
            if (last_bit) begin
                phase   <= PH_IDLE;
                bit_idx <= '0;
            end else begin
                bit_idx <= bit_idx + CNT_W'(1);
            end
        end
    end

    // R3: right after a load the block must refuse the next word.
    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready);

    // R2: a load always opens a shift window.
    a_r2_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && bit_idx == '0));

    // R3: load only happens when ready.
    a_r3_load_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ready);

endmodule

// File: rtl/nls_lane_shifter.sv
// Module: one nibble shift register per lane.
// On load each lane takes its own nibble of the word; while shifting it
// moves towards the MSB and fills with zero, so an idle lane reads 0.
module nls_lane_shifter #(
    parameter int LANES = 8,
    parameter int NIB_W = 4,
    localparam int WORD_W = LANES * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word,
    output logic [LANES-1:0]  lane_out
);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [NIB_W-1:0] nib;

        // Capture this lane's nibble or shift it one place towards the MSB.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib <= '0;
            end else if (load) begin
                nib <= word[n*NIB_W +: NIB_W];
            end else if (shift_en) begin
                nib <= {nib[NIB_W-2:0], 1'b0};
            end
        end

        // Serial output is the nibble MSB.
        assign lane_out[n] = nib[NIB_W-1];
    end

endmodule

// File: rtl/nls_lu_framer.sv
// Module: LU boundary tracker.
// Counts the words left in the current LU, reads the length setting only
// at the first word of an LU, and marks that word as first. A start
// marker on an accepted word always opens a new LU.
module nls_lu_framer
    import nls_pkg::*;
#(
    parameter int CFG_W      = 5,
    parameter int MIN_BYTES  = 16,
    parameter int MAX_BYTES  = 20,
    parameter int WORD_BYTES = 4,
    localparam int MAX_WORDS = (MAX_BYTES + WORD_BYTES - 1) / WORD_BYTES,
    localparam int WCNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sol,
    input  logic [CFG_W-1:0] cfg_bytes,
    output logic             first_q
);

    logic [WCNT_W-1:0] words_left;
    logic              lu_start;
    int unsigned       new_words;

    // A word opens an LU when marked, or when the previous LU is complete.
    assign lu_start  = sol || (words_left == '0);
    // Length of an LU opened now, from the current setting.
    assign new_words = lu_word_count(int'(cfg_bytes), MIN_BYTES, MAX_BYTES,
                                     WORD_BYTES);

    // Load the word budget at an LU start, otherwise spend one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
            first_q    <= 1'b0;
        end else if (accept) begin
            if (lu_start) begin
                words_left <= WCNT_W'(new_words - 1);
                first_q    <= 1'b1;
            end else begin
                words_left <= words_left - WCNT_W'(1);
                first_q    <= 1'b0;
            end
        end
    end

    // R4: the budget never exceeds the longest LU.
    a_r4_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
        words_left <= WCNT_W'(MAX_WORDS - 1));

    // R8: a marked word is always the first word of its LU.
    a_r8_marker_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sol) |=> first_q);

    // R6: words left over hold while no word is accepted.
    a_r6_budget_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(words_left));

endmodule

// File: rtl/nibble_lane_serializer.sv
// Module: top of the nibble-striped lane serializer.
// Accepts one word per four bit-times over valid/ready, stripes its
// nibbles onto eight lanes MSB first and strobes the LU start on every
// lane. Assumes cfg_lu_bytes is stable around the accepting edge.
module nibble_lane_serializer
    import nls_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int NIB_W        = 4,
    parameter int CFG_W        = 5,
    parameter int LU_MIN_BYTES = 16,
    parameter int LU_MAX_BYTES = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CFG_W-1:0]        cfg_lu_bytes,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORD_W-1:0]       in_data,
    input  logic                    in_sol,
    output logic [WORD_W/NIB_W-1:0] lane_data,
    output logic [WORD_W/NIB_W-1:0] lane_frame,
    output logic                    lane_busy
);

    localparam int LANES      = WORD_W / NIB_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BCNT_W     = $clog2(NIB_W);

    logic              accept;
    logic              busy;
    logic              shift_en;
    logic              first_q;
    logic [BCNT_W-1:0] bit_idx;

    // Handshake completes when both sides agree.
    assign accept   = in_valid && in_ready;
    // Shift on every busy cycle that does not reload.
    assign shift_en = busy && !accept;

    nls_bit_timer #(
        .BITS  (NIB_W),
        .CNT_W (BCNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .busy    (busy),
        .bit_idx (bit_idx),
        .ready   (in_ready)
    );

    nls_lane_shifter #(
        .LANES (LANES),
        .NIB_W (NIB_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift_en (shift_en),
        .word     (in_data),
        .lane_out (lane_data)
    );

    nls_lu_framer #(
        .CFG_W      (CFG_W),
        .MIN_BYTES  (LU_MIN_BYTES),
        .MAX_BYTES  (LU_MAX_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sol       (in_sol),
        .cfg_bytes (cfg_lu_bytes),
        .first_q   (first_q)
    );

    // Strobe all lanes on the first bit-time of an LU's first word.
    assign lane_frame = {LANES{first_q && busy && (bit_idx == '0)}};
    assign lane_busy  = busy;

    // R1: each lane's first bit is the top bit of its own nibble.
    for (genvar n = 0; n < LANES; n++) begin : g_chk
        a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> (lane_data[n] == $past(in_data[n*NIB_W + NIB_W - 1])));
    end

    // R7: the strobe lasts a single bit-time.
    a_r7_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        lane_frame[0] |=> !lane_frame[0]);

    // R9: an idle block drives quiet lanes.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_busy |-> (lane_data == '0 && lane_frame == '0 && in_ready));

endmodule

// File: tb/nibble_lane_serializer_test.sv
// Bench: scoreboard for the nibble-striped lane serializer.
module nibble_lane_serializer_test;

    typedef struct {
        logic [31:0] word;
        logic        first;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_lu_bytes = 5'd16;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sol = 1'b0;
    logic [7:0]  lane_data;
    logic [7:0]  lane_frame;
    logic        lane_busy;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;
    exp_t        exp_q[$];
    string       cur_tag  = "R4";
    int          model_left = 0;

    always #2 clk = ~clk;

    nibble_lane_serializer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_lu_bytes (cfg_lu_bytes),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_sol       (in_sol),
        .lane_data    (lane_data),
        .lane_frame   (lane_frame),
        .lane_busy    (lane_busy)
    );

    // Record one comparison.
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int words_for(input int b);
        int c;
        c = (b < 16) ? 16 : ((b > 20) ? 20 : b);
        return (c + 3) / 4;
    endfunction

    // Offer one word; push its expectation at the cycle it is taken.
    task automatic send(input logic [31:0] w, input logic s);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_sol   = s;
        while (!in_ready) @(negedge clk);
        if (s || model_left == 0) begin
            model_left = words_for(int'(cfg_lu_bytes)) - 1;
            e.first = 1'b1;
        end else begin
            model_left--;
            e.first = 1'b0;
        end
        e.word = w;
        e.tag  = cur_tag;
        exp_q.push_back(e);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sol   = 1'b0;
    endtask

    task automatic send_lu(input int nwords, input logic [31:0] seed);
        for (int i = 0; i < nwords; i++)
            send(seed ^ (32'h1111_1111 * i) ^ $urandom, i == 0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: rebuild words from lane bits and compare with the queue.
    int          pos = 0;
    logic [31:0] acc = '0;
    exp_t        cur;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (lane_busy) begin
                if (pos == 0) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected word", 32'(lane_data), 32'h0);
                        cur.word = '0; cur.first = 1'b0; cur.tag = "R2";
                    end else begin
                        cur = exp_q[0];
                    end
                    check(lane_frame == {8{cur.first}}, {"R7 frame/", cur.tag},
                          32'(lane_frame), 32'({8{cur.first}}));
                end else begin
                    check(lane_frame == 8'h00, "R7 frame off", 32'(lane_frame), 32'h0);
                end
                check(in_ready == (pos == 3), "R3 ready", 32'(in_ready), 32'(pos == 3));
                for (int n = 0; n < 8; n++) acc[n*4 + 3 - pos] = lane_data[n];
                if (pos == 3) begin
                    check(acc == cur.word, "R1 word", acc, cur.word);
                    if (exp_q.size() != 0) void'(exp_q.pop_front());
                    pos = 0;
                end else begin
                    pos++;
                end
            end else begin
                check(pos == 0, "R2 short word", 32'(pos), 32'h0);
                check(lane_data == 8'h00 && lane_frame == 8'h00 && in_ready,
                      "R9 idle", {16'h0, lane_data, lane_frame}, 32'h0);
                pos = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !lane_busy && lane_data == 0 && lane_frame == 0,
              "R9 reset", {16'h0, lane_data, lane_frame}, 32'h0);

        // R4: 16-byte LUs back to back, distinct nibble per lane.
        cur_tag = "R4";
        cfg_lu_bytes = 5'd16;
        send(32'h7654_3210, 1'b1);
        send(32'h89AB_CDEF, 1'b0);
        send(32'h8000_0001, 1'b0);
        send(32'h0F0F_F0F0, 1'b0);
        for (int k = 0; k < 8; k++) send(32'h1 << (k * 4 + 3), 1'b0);
        // R4: 20, 17, 18 bytes.
        cfg_lu_bytes = 5'd20;
        send_lu(5, 32'hA5A5_5A5A);
        send_lu(5, 32'h1234_5678);
        cfg_lu_bytes = 5'd17;
        for (int i = 0; i < 10; i++) send($urandom, 1'b0);
        cfg_lu_bytes = 5'd18;
        send_lu(5, 32'hDEAD_BEEF);
        // R5: clamped settings.
        cur_tag = "R5";
        cfg_lu_bytes = 5'd9;
        for (int i = 0; i < 8; i++) send($urandom, 1'b0);
        cfg_lu_bytes = 5'd31;
        for (int i = 0; i < 10; i++) send($urandom, 1'b0);
        cfg_lu_bytes = 5'd0;
        for (int i = 0; i < 4; i++) send($urandom, 1'b0);
        // R6: setting changes in the middle of an LU.
        cur_tag = "R6";
        cfg_lu_bytes = 5'd16;
        send(32'hCAFE_0001, 1'b1);
        cfg_lu_bytes = 5'd20;
        send(32'hCAFE_0002, 1'b0);
        send(32'hCAFE_0003, 1'b0);
        send(32'hCAFE_0004, 1'b0);
        for (int i = 0; i < 5; i++) send(32'hBEEF_0000 + i, 1'b0);
        cfg_lu_bytes = 5'd16;
        send(32'h5555_AAAA, 1'b0);
        send(32'hAAAA_5555, 1'b0);
        // R8: marker in the middle of an LU.
        cur_tag = "R8";
        cfg_lu_bytes = 5'd20;
        send(32'h0000_0011, 1'b1);
        send(32'h0000_0022, 1'b0);
        send(32'h0000_0033, 1'b1);
        for (int i = 0; i < 4; i++) send($urandom, 1'b0);
        send($urandom, 1'b1);
        // R9/R3: idle gaps between words.
        cur_tag = "R9";
        for (int i = 0; i < 6; i++) begin
            send($urandom, 1'b0);
            repeat (i + 1) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        report();
    end

endmodule